// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends one complete CEC message onto the shared open-drain line. Software fills a sixteen-entry byte buffer, then writes a control word that holds the byte count, a start command and two options: the block can insert the start bit and the end-of-message flags itself. The engine waits until the line has been high for the required signal free time. It then drives the optional start bit and sends each byte most significant bit first, followed by an end-of-message bit and an acknowledge slot. The acknowledge slot is sent as a logical 1, and the engine samples it to learn whether a follower pulled the line low.

All timing is counted in ticks of a prescaler. Software sets the divider so that one tick lasts 0.1 ms. While the engine sends the header byte it checks for a lost arbitration. It can also give up on the frame at the first block that is not acknowledged. When the frame ends it leaves sticky done, acknowledge, error and arbitration-lost flags. The engine makes one attempt per start command; any retry is left to the logic above it.

Top module: `cec_tx_engine`

## Requirements
- R1: The prescaler gives one tick every `clk_div` clock cycles, and a value of 0 acts as 1. Every bit duration below is a whole number of ticks.
- R2: Buffer entry k is written at address k. Entry 0 goes out first, and each byte is sent most significant bit first.
- R3: The control word has the byte count in bits [4:0], start in bit 5, automatic start bit in bit 6 and automatic end-of-message in bit 7. A start command written while `busy` is high has no effect.
- R4: A start command with a count of 0 or above 16 sets `tx_done` and `tx_err` on the next cycle and never drives the line.
- R5: Before the first bit, the line must be seen high for N bit periods of 24 ticks each. Any low sample restarts the count. N is 5 when `sft_mode`=0, 7 when it is 1, 3 when it is 2, and 7 when it is 3.
- R6: With bit 6 set, the frame begins with a start bit: 37 ticks low in a 45-tick period. With bit 6 clear, no start bit is sent.
- R7: Every data, end-of-message and acknowledge bit lasts 24 ticks. A 0 is low for 15 ticks and a 1 is low for 6 ticks.
- R8: With bit 7 set, the end-of-message bit is 1 after the last byte and 0 after every other byte. With bit 7 clear, it is always 0. The acknowledge slot is always sent as a 1.
- R9: The acknowledge slot is sampled at tick 10, and a low line counts as acknowledged. At completion, `tx_ack` is 1 only if every block was acknowledged.
- R10: With `stop_on_nack` high, the frame ends at the first block that is not acknowledged, with `tx_done` set and `tx_ack` clear.
- R11: While sending a 1 in a header data bit, a low line at tick 10 means arbitration is lost. The engine releases the line, ends the frame and sets `tx_arb_lost`, with `tx_ack` clear.
- R12: An accepted start clears all four flags and raises `busy` until completion. The flags then hold until the next accepted start. The line is never driven while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | 16 | Clock cycles per timing tick |
| buf_we | input | 1 | Buffer write strobe |
| buf_addr | input | 4 | Buffer entry index |
| buf_wdata | input | 8 | Byte to store |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word: count, start, auto start bit, auto end-of-message |
| sft_mode | input | 2 | Signal free time selection |
| stop_on_nack | input | 1 | Abandon the frame on the first missing acknowledge |
| cec_line_in | input | 1 | Sampled level of the shared line |
| cec_drive_low | output | 1 | Pull the line low when high |
| busy | output | 1 | A frame is in progress |
| tx_done | output | 1 | The last frame has completed |
| tx_ack | output | 1 | Every block of the last frame was acknowledged |
| tx_err | output | 1 | The last start command had an invalid count |
| tx_arb_lost | output | 1 | The last frame lost arbitration |

## Verification
The checks assume that `clk_div` and the buffer contents stay fixed while `busy` is high. They also assume that the line input only reflects this engine's own drive, a follower's acknowledge pull and deliberate contention. The bench changes the divider and rewrites the buffer only between frames. A bus model in the bench pulls the line low only in acknowledge slots, at a chosen header bit, or while the line is held before a start, so every low level the engine sees has a known cause. The bench also issues control writes with invalid counts and a start command during a frame, to show these are rejected or ignored.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SFT   = 2'd1,
    ST_START = 2'd2,
    ST_BIT   = 2'd3
  } tx_state_e;

  typedef struct packed {
    logic done;
    logic ack;
    logic err;
    logic arb;
  } tx_flags_t;
endpackage

// File: rtl/cec_rst_sync.sv
module cec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = (div == '0) ? '0 : div - DIV_W'(1);
    tick  = (cnt_q >= lim);
    cnt_d = tick ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cec_tx_buf.sv
module cec_tx_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic en;
    assign en = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[i] <= '0;
      else if (en) mem_q[i] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/cec_tx_fsm.sv
module cec_tx_fsm
  import cec_tx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int DW          = 8,
  parameter int T_START_LOW = 37,
  parameter int T_START_PER = 45,
  parameter int T_ZERO_LOW  = 15,
  parameter int T_ONE_LOW   = 6,
  parameter int T_BIT_PER   = 24,
  parameter int T_SAMPLE    = 10,
  parameter int SFT_NEW     = 5,
  parameter int SFT_CONT    = 7,
  parameter int SFT_RETX    = 3,
  localparam int AW         = $clog2(DEPTH),
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_req,
  input  logic [CW-1:0] cmd_count,
  input  logic          cmd_som,
  input  logic          cmd_eom,
  input  logic [1:0]    sft_mode,
  input  logic          stop_on_nack,
  input  logic          line_in,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          drive_low,
  output logic          busy,
  output tx_flags_t     flags
);
  localparam int TW      = $clog2(T_START_PER + 1);
  localparam int SFT_M1  = (SFT_CONT > SFT_NEW) ? SFT_CONT : SFT_NEW;
  localparam int SFT_MAX = ((SFT_M1 > SFT_RETX) ? SFT_M1 : SFT_RETX) * T_BIT_PER;
  localparam int SW      = $clog2(SFT_MAX + 1);
  localparam int N_BITS  = DW + 2;
  localparam int BPW     = $clog2(N_BITS);
  localparam int DBW     = $clog2(DW);

  tx_state_e     state_q, state_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [SW-1:0] sft_q, sft_d, sft_target;
  logic [BPW-1:0] bitpos_q, bitpos_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [CW-1:0] count_q, count_d;
  logic          som_q, som_d, eom_q, eom_d, stop_q, stop_d;
  logic [1:0]    mode_q, mode_d;
  logic          ack_all_q, ack_all_d;
  tx_flags_t     flags_q, flags_d;
  logic [1:0]    sync_q;
  logic          line_s;

  logic count_ok, is_data_bit, is_eom_bit, is_ack_bit, last_byte;
  logic in_header, bit_val, at_sample, at_bit_end;
  logic [TW-1:0] low_len;
  logic [DBW-1:0] data_sel;

  // two-stage synchronizer on the shared line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_in};
  end
  assign line_s = sync_q[1];

  always_comb begin
    count_ok    = (cmd_count != '0) && (cmd_count <= CW'(DEPTH));
    is_data_bit = (bitpos_q < BPW'(DW));
    is_eom_bit  = (bitpos_q == BPW'(DW));
    is_ack_bit  = (bitpos_q == BPW'(DW + 1));
    last_byte   = (CW'(idx_q) == count_q - CW'(1));
    in_header   = (idx_q == '0) && is_data_bit;
    data_sel    = DBW'(DW - 1) - bitpos_q[DBW-1:0];
    if (is_data_bit)     bit_val = rd_data[data_sel];
    else if (is_eom_bit) bit_val = eom_q && last_byte;
    else                 bit_val = 1'b1;
    low_len    = bit_val ? TW'(T_ONE_LOW) : TW'(T_ZERO_LOW);
    at_sample  = (tcnt_q == TW'(T_SAMPLE));
    at_bit_end = (tcnt_q == TW'(T_BIT_PER - 1));
    case (mode_q)
      2'd0:    sft_target = SW'(SFT_NEW * T_BIT_PER);
      2'd2:    sft_target = SW'(SFT_RETX * T_BIT_PER);
      default: sft_target = SW'(SFT_CONT * T_BIT_PER);
    endcase
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    tcnt_d    = tcnt_q;
    sft_d     = sft_q;
    bitpos_d  = bitpos_q;
    idx_d     = idx_q;
    count_d   = count_q;
    som_d     = som_q;
    eom_d     = eom_q;
    stop_d    = stop_q;
    mode_d    = mode_q;
    ack_all_d = ack_all_q;
    flags_d   = flags_q;
    case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          flags_d   = '0;
          count_d   = cmd_count;
          som_d     = cmd_som;
          eom_d     = cmd_eom;
          stop_d    = stop_on_nack;
          mode_d    = sft_mode;
          idx_d     = '0;
          bitpos_d  = '0;
          tcnt_d    = '0;
          sft_d     = '0;
          ack_all_d = 1'b1;
          if (count_ok) begin
            state_d = ST_SFT;
          end else begin
            flags_d.done = 1'b1;
            flags_d.err  = 1'b1;
          end
        end
      end
      ST_SFT: begin
        if (tick) begin
          if (!line_s) begin
            sft_d = '0;
          end else if (sft_q == sft_target - SW'(1)) begin
            sft_d    = '0;
            tcnt_d   = '0;
            bitpos_d = '0;
            idx_d    = '0;
            state_d  = som_q ? ST_START : ST_BIT;
          end else begin
            sft_d = sft_q + SW'(1);
          end
        end
      end
      ST_START: begin
        if (tick) begin
          if (tcnt_q == TW'(T_START_PER - 1)) begin
            tcnt_d  = '0;
            state_d = ST_BIT;
          end else begin
            tcnt_d = tcnt_q + TW'(1);
          end
        end
      end
      ST_BIT: begin
        if (tick) begin
          tcnt_d = tcnt_q + TW'(1);
          if (at_sample && in_header && bit_val && !line_s) begin
            state_d      = ST_IDLE;
            flags_d.done = 1'b1;
            flags_d.arb  = 1'b1;
            flags_d.ack  = 1'b0;
          end else if (at_sample && is_ack_bit && line_s) begin
            ack_all_d = 1'b0;
            if (stop_q) begin
              state_d      = ST_IDLE;
              flags_d.done = 1'b1;
              flags_d.ack  = 1'b0;
            end
          end else if (at_bit_end) begin
            tcnt_d = '0;
            if (is_ack_bit) begin
              if (last_byte) begin
                state_d      = ST_IDLE;
                flags_d.done = 1'b1;
                flags_d.ack  = ack_all_q;
              end else begin
                idx_d    = idx_q + AW'(1);
                bitpos_d = '0;
              end
            end else begin
              bitpos_d = bitpos_q + BPW'(1);
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tcnt_q    <= '0;
      sft_q     <= '0;
      bitpos_q  <= '0;
      idx_q     <= '0;
      count_q   <= '0;
      som_q     <= 1'b0;
      eom_q     <= 1'b0;
      stop_q    <= 1'b0;
      mode_q    <= 2'd0;
      ack_all_q <= 1'b0;
      flags_q   <= '0;
    end else begin
      state_q   <= state_d;
      tcnt_q    <= tcnt_d;
      sft_q     <= sft_d;
      bitpos_q  <= bitpos_d;
      idx_q     <= idx_d;
      count_q   <= count_d;
      som_q     <= som_d;
      eom_q     <= eom_d;
      stop_q    <= stop_d;
      mode_q    <= mode_d;
      ack_all_q <= ack_all_d;
      flags_q   <= flags_d;
    end
  end

  assign rd_addr   = idx_q;
  assign busy      = (state_q != ST_IDLE);
  assign flags     = flags_q;
  assign drive_low = ((state_q == ST_START) && (tcnt_q < TW'(T_START_LOW))) ||
                     ((state_q == ST_BIT)   && (tcnt_q < low_len));
endmodule

// File: rtl/cec_tx_engine.sv
module cec_tx_engine
  import cec_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int DIV_W = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [DW-1:0] buf_wdata,
  input  logic          ctl_we,
  input  logic [CW+2:0] ctl_wdata,
  input  logic [1:0]    sft_mode,
  input  logic          stop_on_nack,
  input  logic          cec_line_in,
  output logic          cec_drive_low,
  output logic          busy,
  output logic          tx_done,
  output logic          tx_ack,
  output logic          tx_err,
  output logic          tx_arb_lost
);
  localparam int F_START = CW;
  localparam int F_SOM   = CW + 1;
  localparam int F_EOM   = CW + 2;

  logic          rst_n_s, tick, start_req;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  tx_flags_t     flags;

  assign start_req = ctl_we && ctl_wdata[F_START];

  cec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cec_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n_s),
    .div   (clk_div),
    .tick  (tick)
  );

  cec_tx_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (buf_we),
    .waddr (buf_addr),
    .wdata (buf_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  cec_tx_fsm #(.DEPTH(DEPTH), .DW(DW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .tick         (tick),
    .start_req    (start_req),
    .cmd_count    (ctl_wdata[CW-1:0]),
    .cmd_som      (ctl_wdata[F_SOM]),
    .cmd_eom      (ctl_wdata[F_EOM]),
    .sft_mode     (sft_mode),
    .stop_on_nack (stop_on_nack),
    .line_in      (cec_line_in),
    .rd_data      (rd_data),
    .rd_addr      (rd_addr),
    .drive_low    (cec_drive_low),
    .busy         (busy),
    .flags        (flags)
  );

  assign tx_done     = flags.done;
  assign tx_ack      = flags.ack;
  assign tx_err      = flags.err;
  assign tx_arb_lost = flags.arb;
endmodule

// File: rtl/cec_tx_engine_chk.sv
module cec_tx_engine_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [CW+2:0] ctl_wdata,
  input logic          cec_drive_low,
  input logic          busy,
  input logic          tx_done,
  input logic          tx_ack,
  input logic          tx_err,
  input logic          tx_arb_lost
);
  logic start_cmd, bad_cnt;
  assign start_cmd = ctl_we && ctl_wdata[CW];
  assign bad_cnt   = (ctl_wdata[CW-1:0] == '0) || (ctl_wdata[CW-1:0] > CW'(DEPTH));

  AST_IDLE_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cec_drive_low); // R12
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_cmd)); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> !busy); // R12
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_cmd) |=> $stable({tx_done, tx_ack, tx_err, tx_arb_lost})); // R12
  AST_BAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !busy && bad_cnt) |=> (tx_done && tx_err && !busy)); // R4
  AST_ERR_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> tx_done); // R4
  AST_ARB_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_arb_lost |-> (!tx_ack && tx_done)); // R11
endmodule

bind cec_tx_engine cec_tx_engine_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_cec_tx_engine.sv
module sim_cec_tx_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] clk_div;
  logic        buf_we;
  logic [3:0]  buf_addr;
  logic [7:0]  buf_wdata;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic [1:0]  sft_mode;
  logic        stop_on_nack;
  logic        cec_line_in;
  logic        cec_drive_low, busy, tx_done, tx_ack, tx_err, tx_arb_lost;

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus model state
  int  fol_cnt = 0, arb_cnt = 0;
  logic ext_low = 1'b0;
  assign cec_line_in = !(cec_drive_low || (fol_cnt > 0) || (arb_cnt > 0) || ext_low);

  logic [15:0] ack_mask = '0;
  bit   arb_on = 0;
  int   arb_bit = 0;
  int   mon_div = 2;
  int   mon_bitpos = 0, mon_byte = 0, popped = 0, starts = 0, total_falls = 0;
  int   first_fall = -1, last_fall = 0, lowcnt = 0;
  bit   last_was_data = 0;
  logic prev_drv = 1'b0;
  logic [8:0] cur = '0;
  logic [8:0] exp_q [$];
  logic [7:0] fdata [16];

  cec_tx_engine u0 (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .sft_mode(sft_mode),
    .stop_on_nack(stop_on_nack), .cec_line_in(cec_line_in), .cec_drive_low(cec_drive_low),
    .busy(busy), .tx_done(tx_done), .tx_ack(tx_ack), .tx_err(tx_err), .tx_arb_lost(tx_arb_lost)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sft_bits(input logic [1:0] m);
    case (m)
      2'd0: return 5;
      2'd2: return 3;
      default: return 7;
    endcase
  endfunction

  // monitor: decodes pulses on the engine drive, plays follower and contender
  always @(negedge clk) begin
    int width;
    logic val;
    logic [8:0] e;
    if (fol_cnt > 0) fol_cnt--;
    if (arb_cnt > 0) arb_cnt--;
    if (cec_drive_low && !prev_drv) begin
      total_falls++;
      if (first_fall < 0) first_fall = cyc;
      else if (last_was_data)
        chk(cyc - last_fall == 24 * mon_div, "R7", "bit period", cyc - last_fall, 24 * mon_div);
      last_fall = cyc;
      if (mon_bitpos == 9 && mon_byte < 16 && ack_mask[mon_byte]) fol_cnt = 15 * mon_div;
      if (arb_on && mon_byte == 0 && mon_bitpos == arb_bit) arb_cnt = 15 * mon_div;
      lowcnt = 1;
    end else if (cec_drive_low) begin
      lowcnt++;
    end else if (prev_drv) begin
      width = lowcnt;
      if (width == 37 * mon_div) begin
        starts++;
        mon_bitpos = 0;
        last_was_data = 0;
      end else begin
        val = (width == 6 * mon_div);
        chk(width == 6 * mon_div || width == 15 * mon_div, "R7", "low width", width, 6 * mon_div);
        last_was_data = 1;
        if (mon_bitpos < 9) cur = {cur[7:0], val};
        if (mon_bitpos == 8) begin
          if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(cur == e, "R2 R8", "byte+eom", cur, e);
            popped++;
          end else chk(1'b0, "R2", "unexpected byte", cur, 0);
        end
        if (mon_bitpos == 9) chk(val == 1'b1, "R8", "ack slot sent as 1", val, 1);
        mon_bitpos++;
        if (mon_bitpos == 10) begin
          mon_bitpos = 0;
          mon_byte++;
        end
      end
    end
    prev_drv = cec_drive_low;
  end

  // driver: loads buffer, queues expected blocks, starts, then checks result
  task automatic send_frame(input int n, input bit som, input bit eom, input logic [1:0] mode,
                            input bit son, input logic [15:0] ackm, input bit arb, input int abit,
                            input int hold, input bit spur, input int exp_sent,
                            input bit exp_ack, input bit exp_arb);
    int ref_cyc, tgt, falls_at_end;
    bit got;
    for (int k = 15; k >= 0; k--) begin
      @(negedge clk);
      buf_we = 1'b1; buf_addr = 4'(k); buf_wdata = fdata[k];
    end
    @(negedge clk);
    buf_we = 1'b0;
    exp_q.delete();
    for (int k = 0; k < n; k++) exp_q.push_back({fdata[k], (eom && k == n - 1)});
    mon_div = (clk_div == 0) ? 1 : int'(clk_div);
    mon_bitpos = 0; mon_byte = 0; popped = 0; starts = 0; first_fall = -1;
    last_was_data = 0; ack_mask = ackm; arb_on = arb; arb_bit = abit;
    sft_mode = mode; stop_on_nack = son;
    if (hold > 0) ext_low = 1'b1;
    ctl_we = 1'b1; ctl_wdata = {eom, som, 1'b1, 5'(n)};
    ref_cyc = cyc;
    @(negedge clk);
    ctl_we = 1'b0;
    chk(busy == 1'b1, "R12", "busy after start", busy, 1);
    chk({tx_done, tx_ack, tx_err, tx_arb_lost} == 4'b0, "R12", "flags cleared",
        {tx_done, tx_ack, tx_err, tx_arb_lost}, 0);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      ext_low = 1'b0;
      ref_cyc = cyc;
    end
    if (spur) begin
      repeat (300) @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = 8'b1110_0001;
      @(negedge clk);
      ctl_we = 1'b0;
    end
    got = 0;
    for (int w = 0; w < 80000; w++) begin
      @(negedge clk);
      if (tx_done) begin got = 1; break; end
    end
    chk(got, "R12", "frame completes", got, 1);
    tgt = sft_bits(mode) * 24 * mon_div;
    chk(first_fall - ref_cyc >= tgt - 1 && first_fall - ref_cyc <= tgt + mon_div + 5,
        "R5", "free time before first bit", first_fall - ref_cyc, tgt);
    chk(starts == int'(som), "R6", "start bits seen", starts, int'(som));
    chk(popped == exp_sent, "R9 R10 R11", "blocks completed", popped, exp_sent);
    chk(tx_ack == exp_ack, "R9", "tx_ack", tx_ack, exp_ack);
    chk(tx_arb_lost == exp_arb, "R11", "tx_arb_lost", tx_arb_lost, exp_arb);
    chk(tx_err == 1'b0, "R4", "no error on valid count", tx_err, 0);
    chk(busy == 1'b0, "R12", "idle after done", busy, 0);
    falls_at_end = total_falls;
    repeat (120) @(negedge clk);
    chk(total_falls == falls_at_end, "R11 R12", "line quiet after done", total_falls, falls_at_end);
    arb_on = 0;
  endtask

  task automatic bad_count(input logic [4:0] cnt);
    int f0;
    f0 = total_falls;
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = {3'b111, cnt};
    @(negedge clk);
    ctl_we = 1'b0;
    chk(tx_done && tx_err && !busy, "R4", "bad count rejected", {tx_done, tx_err, busy}, 3'b110);
    repeat (60) @(negedge clk);
    chk(total_falls == f0, "R4", "no drive on bad count", total_falls, f0);
    chk(tx_done && tx_err, "R12", "flags hold", {tx_done, tx_err}, 2'b11);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_div = 16'd2; buf_we = 1'b0; buf_addr = '0; buf_wdata = '0;
    ctl_we = 1'b0; ctl_wdata = '0; sft_mode = 2'd0; stop_on_nack = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({busy, tx_done, tx_ack, tx_err, tx_arb_lost, cec_drive_low} == 6'b0, "R12",
        "reset state", {busy, tx_done, tx_ack, tx_err, tx_arb_lost, cec_drive_low}, 0);

    // R2 R8: three bytes, all acknowledged
    fdata[0] = 8'h45; fdata[1] = 8'h9A; fdata[2] = 8'hC3;
    for (int k = 3; k < 16; k++) fdata[k] = 8'(k * 17 + 3);
    send_frame(3, 1, 1, 2'd0, 0, 16'hFFFF, 0, 0, 0, 0, 3, 1, 0);

    // R1 R5: full buffer, divider 3, continuing initiator
    clk_div = 16'd3;
    send_frame(16, 1, 1, 2'd1, 0, 16'hFFFF, 0, 0, 0, 0, 16, 1, 0);

    // R1 R6 R8: divider 0, no start bit, no end-of-message, retransmit time
    clk_div = 16'd0;
    send_frame(1, 0, 0, 2'd2, 0, 16'hFFFF, 0, 0, 0, 0, 1, 1, 0);

    // R10: second block not acknowledged, stop enabled
    clk_div = 16'd2;
    send_frame(3, 1, 1, 2'd0, 1, 16'h0001, 0, 0, 0, 0, 2, 0, 0);
    // R9: same without stop, frame runs to the end
    send_frame(3, 1, 1, 2'd0, 0, 16'h0001, 0, 0, 0, 0, 3, 0, 0);

    // R11: contention on header bit 1 (a 1 in 0x45)
    send_frame(2, 1, 1, 2'd0, 0, 16'hFFFF, 1, 1, 0, 0, 0, 0, 1);

    // R5: line held low before start restarts the free time count; mode 3
    send_frame(2, 1, 1, 2'd3, 0, 16'hFFFF, 0, 0, 200, 0, 2, 1, 0);

    // R3: start written while busy is ignored
    send_frame(4, 1, 1, 2'd0, 0, 16'hFFFF, 0, 0, 0, 1, 4, 1, 0);

    // R4: invalid counts
    bad_count(5'd0);
    bad_count(5'd17);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule